// File: doc/BRIEF.md
# Logic Cluster Local Interconnect with Broadcast Feedback

This block is the routing fabric inside one logic cluster of a mesh programmable array. An upward crossbar picks, for each line of a 16-line local bus, one of 24 external cluster inputs. Four downward crossbars each drive 10 logic-block input pins.

Each downward crossbar selects among three groups of sources: the local bus lines, two cluster outputs reserved for that crossbar alone, and four cluster outputs that are broadcast to every downward crossbar. Because the four broadcast outputs can be reached through any of the four downward crossbars, a route that would pass through a broken selector can be moved to a healthy one in another crossbar.

Twelve small registered look-up-table stubs close the loop and produce the cluster outputs. Logic block j takes input bit k from pin (j mod 10) of downward crossbar k.

A single serially loaded configuration image holds the following:
- every upward and downward select field;
- a per-pin defect map, which forces a marked downward pin to a known 0;
- the twelve truth tables.

A test port can force any one routing selector output to a stuck value, so that rerouted configurations can be exercised.

Top module: `cluster_local_route`

## Requirements
- R1: While rst_n is low, clu_out is 0 and cfg_ready is 0. From the first rising edge with rst_n high, cfg_ready is 1. The configuration image resets to all zeros, and with an all-zero image every output stays 0.
- R2: One configuration bit is accepted on each rising edge where cfg_valid and cfg_ready are both 1. The image shifts toward bit 0, so after 512 accepted bits the first bit sent sits at image bit 0. Bits offered with cfg_valid low are ignored. Image layout:
  - bits 0..79 hold the 5-bit upward select of bus line b at 5b;
  - bits 80..279 hold the 5-bit downward select of crossbar x, pin p at 80+5(10x+p);
  - bits 280..319 hold the defect bit of crossbar x, pin p at 280+10x+p;
  - bits 320..511 hold the 16-entry table of logic block j at 320+16j.
- R3: Bus line b carries ext_in[s] for an upward select s below 24, and 0 for s from 24 to 31.
- R4: In downward crossbar x, select codes map as follows:
  - codes 0..15 pick bus line s;
  - code 16 picks cluster output 2x and code 17 picks output 2x+1;
  - codes 18..21 pick broadcast outputs 8..11 in every crossbar;
  - codes 22..31 give 0.
- R5: Logic block j forms a 4-bit address whose bit k is pin (j mod 10) of crossbar k. clu_out[j] takes the table bit at that address on the next rising edge.
- R6: Feedback goes through the output registers. A value on clu_out reaches any logic block as a feedback input one cycle later and never forms a combinational loop.
- R7: A downward pin whose defect bit is 1 reads 0, whatever its select code and any forced fault on it.
- R8: With flt_en at 1, the selector output numbered flt_idx is forced to flt_val. Numbers 0..15 are the bus lines, 16+10x+p is crossbar x pin p, and numbers 56..63 have no effect.
- R9: When a broadcast feedback route in one crossbar has a stuck fault, marking that pin defective and routing the same signal through another crossbar, with the truth table permuted to match, restores the logic function.
- R10: A completed configuration takes effect on the first rising edge after the edge that accepts its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration bit offered |
| cfg_bit | input | 1 | Configuration data bit |
| cfg_ready | output | 1 | Configuration port can accept a bit |
| ext_in | input | 24 | External cluster inputs |
| flt_en | input | 1 | Enable stuck-value forcing |
| flt_idx | input | 6 | Number of the forced selector output |
| flt_val | input | 1 | Forced value |
| clu_out | output | 12 | Registered cluster outputs |

## Verification
The hardest situation to reach is a live feedback signal that crosses a forced fault and is then rerouted through a second crossbar. This needs a configuration in which one block toggles on its own feedback and another block copies it through a broadcast code. The bench therefore loads a hand-built image of that kind, forces the copying pin stuck, and reloads an image that marks the pin defective and moves the route to another crossbar with a permuted table. Randomly drawn images, faults and input patterns cover the select codes in general, including the zero codes and fault numbers above the last selector.

// File: rtl/clr_pkg.sv
package clr_pkg;
  // select width: n real sources plus at least one code that yields 0
  function automatic int unsigned sel_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  // width of a selector number across upward and downward crossbars
  function automatic int unsigned mux_id_w(input int unsigned bus_n,
                                           input int unsigned xd_n,
                                           input int unsigned pin_n);
    return $clog2(bus_n + xd_n * pin_n);
  endfunction
endpackage

// File: rtl/clr_cfg_shift.sv
module clr_cfg_shift #(
  parameter int unsigned W = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_bit,
  output logic         in_ready,
  output logic [W-1:0] image
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      image    <= '0;
    end else begin
      in_ready <= 1'b1;
      if (in_valid && in_ready) image <= {in_bit, image[W-1:1]};
    end
  end
endmodule

// File: rtl/clr_up_xbar.sv
module clr_up_xbar #(
  parameter int unsigned SRC_N  = 24,
  parameter int unsigned LINE_N = 16,
  parameter int unsigned SW     = 5,
  parameter int unsigned IW     = 6
) (
  input  logic [SRC_N-1:0]     src,
  input  logic [LINE_N*SW-1:0] sel,
  input  logic                 flt_en,
  input  logic [IW-1:0]        flt_idx,
  input  logic                 flt_val,
  output logic [LINE_N-1:0]    line
);
  localparam int unsigned PADDED = 1 << SW;
  localparam int unsigned PAD    = PADDED - SRC_N;

  logic [PADDED-1:0] src_pad;
  assign src_pad = {{PAD{1'b0}}, src};

  for (genvar b = 0; b < LINE_N; b++) begin : g_line
    logic [SW-1:0] s;
    logic          pick;
    assign s       = sel[b*SW +: SW];
    assign pick    = src_pad[s];
    assign line[b] = (flt_en && flt_idx == IW'(b)) ? flt_val : pick;
  end
endmodule

// File: rtl/clr_down_xbar.sv
module clr_down_xbar #(
  parameter int unsigned BUS_N    = 16,
  parameter int unsigned SH_N     = 4,
  parameter int unsigned PIN_N    = 10,
  parameter int unsigned SW       = 5,
  parameter int unsigned IW       = 6,
  parameter int unsigned MUX_BASE = 16
) (
  input  logic [BUS_N-1:0]    line,
  input  logic [1:0]          own_fb,
  input  logic [SH_N-1:0]     bcast_fb,
  input  logic [PIN_N*SW-1:0] sel,
  input  logic [PIN_N-1:0]    defect,
  input  logic                flt_en,
  input  logic [IW-1:0]       flt_idx,
  input  logic                flt_val,
  output logic [PIN_N-1:0]    pin
);
  localparam int unsigned SRC_N  = BUS_N + 2 + SH_N;
  localparam int unsigned PADDED = 1 << SW;
  localparam int unsigned PAD    = PADDED - SRC_N;

  logic [PADDED-1:0] src_pad;
  assign src_pad = {{PAD{1'b0}}, bcast_fb, own_fb, line};

  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    logic [SW-1:0] s;
    logic          pick;
    logic          forced;
    assign s      = sel[p*SW +: SW];
    assign pick   = src_pad[s];
    assign forced = (flt_en && flt_idx == IW'(MUX_BASE + p)) ? flt_val : pick;
    assign pin[p] = defect[p] ? 1'b0 : forced;
  end
endmodule

// File: rtl/clr_lut_bank.sv
module clr_lut_bank #(
  parameter int unsigned OUT_N = 12,
  parameter int unsigned K     = 4,
  parameter int unsigned PIN_N = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [K*PIN_N-1:0]        pins,
  input  logic [OUT_N*(1<<K)-1:0]   tables,
  output logic [OUT_N-1:0]          q
);
  localparam int unsigned T = 1 << K;

  logic [OUT_N-1:0] d;

  for (genvar j = 0; j < OUT_N; j++) begin : g_blk
    localparam int unsigned ROW = j % PIN_N;
    logic [K-1:0] addr;
    logic [T-1:0] tbl;
    for (genvar k = 0; k < K; k++) begin : g_in
      assign addr[k] = pins[k*PIN_N + ROW];
    end
    assign tbl  = tables[j*T +: T];
    assign d[j] = tbl[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cluster_local_route.sv
module cluster_local_route #(
  parameter int unsigned EXT_N = 24,
  parameter int unsigned BUS_N = 16,
  parameter int unsigned XD_N  = 4,
  parameter int unsigned PIN_N = 10,
  parameter int unsigned OUT_N = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  input  logic                 cfg_bit,
  output logic                 cfg_ready,
  input  logic [EXT_N-1:0]     ext_in,
  input  logic                 flt_en,
  input  logic [clr_pkg::mux_id_w(BUS_N, XD_N, PIN_N)-1:0] flt_idx,
  input  logic                 flt_val,
  output logic [OUT_N-1:0]     clu_out
);
  localparam int unsigned IW       = clr_pkg::mux_id_w(BUS_N, XD_N, PIN_N);
  localparam int unsigned SH_N     = OUT_N - 2 * XD_N;
  localparam int unsigned UPW      = clr_pkg::sel_w(EXT_N);
  localparam int unsigned DNW      = clr_pkg::sel_w(BUS_N + 2 + SH_N);
  localparam int unsigned PINS_T   = XD_N * PIN_N;
  localparam int unsigned TBL      = 1 << XD_N;
  localparam int unsigned UP_BITS  = BUS_N * UPW;
  localparam int unsigned DN_LO    = UP_BITS;
  localparam int unsigned DN_BITS  = PINS_T * DNW;
  localparam int unsigned DEF_LO   = DN_LO + DN_BITS;
  localparam int unsigned LUT_LO   = DEF_LO + PINS_T;
  localparam int unsigned LUT_BITS = OUT_N * TBL;
  localparam int unsigned CFG_W    = LUT_LO + LUT_BITS;

  logic [CFG_W-1:0]  cfg_image;
  logic [BUS_N-1:0]  bus;
  logic [PINS_T-1:0] dn_pins;
  logic [PINS_T-1:0] dn_defect;
  logic [SH_N-1:0]   bcast;

  assign dn_defect = cfg_image[DEF_LO +: PINS_T];
  assign bcast     = clu_out[OUT_N-1 : 2*XD_N];

  clr_cfg_shift #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .in_valid(cfg_valid), .in_bit(cfg_bit),
    .in_ready(cfg_ready), .image(cfg_image)
  );

  clr_up_xbar #(.SRC_N(EXT_N), .LINE_N(BUS_N), .SW(UPW), .IW(IW)) u_up (
    .src(ext_in), .sel(cfg_image[0 +: UP_BITS]),
    .flt_en(flt_en), .flt_idx(flt_idx), .flt_val(flt_val), .line(bus)
  );

  for (genvar x = 0; x < XD_N; x++) begin : g_dn
    clr_down_xbar #(
      .BUS_N(BUS_N), .SH_N(SH_N), .PIN_N(PIN_N), .SW(DNW), .IW(IW),
      .MUX_BASE(BUS_N + x * PIN_N)
    ) u_dn (
      .line(bus),
      .own_fb(clu_out[2*x +: 2]),
      .bcast_fb(bcast),
      .sel(cfg_image[DN_LO + x*PIN_N*DNW +: PIN_N*DNW]),
      .defect(dn_defect[x*PIN_N +: PIN_N]),
      .flt_en(flt_en), .flt_idx(flt_idx), .flt_val(flt_val),
      .pin(dn_pins[x*PIN_N +: PIN_N])
    );
  end

  clr_lut_bank #(.OUT_N(OUT_N), .K(XD_N), .PIN_N(PIN_N)) u_lut (
    .clk(clk), .rst_n(rst_n), .pins(dn_pins),
    .tables(cfg_image[LUT_LO +: LUT_BITS]), .q(clu_out)
  );
endmodule

// File: rtl/clr_checker.sv
module clr_checker #(
  parameter int unsigned BUS_N  = 16,
  parameter int unsigned PINS_T = 40,
  parameter int unsigned OUT_N  = 12,
  parameter int unsigned CFG_W  = 512,
  parameter int unsigned IW     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [CFG_W-1:0]  cfg_image,
  input logic [PINS_T-1:0] dn_pins,
  input logic [PINS_T-1:0] dn_defect,
  input logic              flt_en,
  input logic [IW-1:0]     flt_idx,
  input logic              flt_val,
  input logic [OUT_N-1:0]  clu_out
);
  logic hit, hit_pin, hit_def;
  always_comb begin
    hit = 1'b0; hit_pin = 1'b0; hit_def = 1'b0;
    for (int i = 0; i < int'(PINS_T); i++) begin
      if (flt_en && int'(flt_idx) == int'(BUS_N) + i) begin
        hit = 1'b1; hit_pin = dn_pins[i]; hit_def = dn_defect[i];
      end
    end
  end

  p_out_clear_in_reset_r1: assert property (@(posedge clk)
    !rst_n |=> clu_out == '0);

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cfg_ready);

  p_image_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_ready) |=> $stable(cfg_image));

  p_defect_pin_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_pins & dn_defect) == '0);

  p_fault_forces_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !hit_def) |-> hit_pin == flt_val);
endmodule

bind cluster_local_route clr_checker #(
  .BUS_N(BUS_N), .PINS_T(PINS_T), .OUT_N(OUT_N), .CFG_W(CFG_W), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .cfg_image(cfg_image), .dn_pins(dn_pins), .dn_defect(dn_defect),
  .flt_en(flt_en), .flt_idx(flt_idx), .flt_val(flt_val), .clu_out(clu_out)
);

// File: tb/cluster_local_route_test.sv
module cluster_local_route_test;
  localparam int CLK_P = 10;
  localparam int W     = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_bit = 1'b0;
  logic        cfg_ready;
  logic [23:0] ext_in = '0;
  logic        flt_en = 1'b0;
  logic [5:0]  flt_idx = '0;
  logic        flt_val = 1'b0;
  logic [11:0] clu_out;

  cluster_local_route uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_bit(cfg_bit),
    .cfg_ready(cfg_ready), .ext_in(ext_in), .flt_en(flt_en),
    .flt_idx(flt_idx), .flt_val(flt_val), .clu_out(clu_out)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] img;
  logic [11:0]  mq;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected next outputs computed from the requirement text
  function automatic logic [11:0] model(input logic [W-1:0] im, input logic [23:0] ex,
                                        input logic [11:0] q, input logic fe,
                                        input logic [5:0] fi, input logic fv);
    logic [15:0] bus;
    logic [39:0] pin;
    logic [11:0] r;
    logic [3:0]  a;
    logic        v;
    int          s;
    for (int b = 0; b < 16; b++) begin
      s = int'(im[b*5 +: 5]);
      bus[b] = (s < 24) ? ex[s] : 1'b0;
      if (fe && int'(fi) == b) bus[b] = fv;
    end
    for (int x = 0; x < 4; x++) begin
      for (int p = 0; p < 10; p++) begin
        int n;
        n = x*10 + p;
        s = int'(im[80 + n*5 +: 5]);
        if (s < 16)       v = bus[s];
        else if (s == 16) v = q[2*x];
        else if (s == 17) v = q[2*x+1];
        else if (s < 22)  v = q[8 + s - 18];
        else              v = 1'b0;
        if (fe && int'(fi) == 16 + n) v = fv;
        if (im[280 + n]) v = 1'b0;
        pin[n] = v;
      end
    end
    for (int j = 0; j < 12; j++) begin
      for (int k = 0; k < 4; k++) a[k] = pin[k*10 + (j % 10)];
      r[j] = im[320 + j*16 + int'(a)];
    end
    return r;
  endfunction

  task automatic set_up(input int b, input int s);
    img[b*5 +: 5] = 5'(s);
  endtask
  task automatic set_dn(input int x, input int p, input int s);
    img[80 + (x*10+p)*5 +: 5] = 5'(s);
  endtask
  task automatic set_def(input int x, input int p, input logic v);
    img[280 + x*10 + p] = v;
  endtask
  task automatic set_lut(input int j, input logic [15:0] t);
    img[320 + j*16 +: 16] = t;
  endtask

  task automatic rand_img(input int fb_bias, input int def_rate);
    for (int b = 0; b < 16; b++) set_up(b, $urandom % 32);
    for (int x = 0; x < 4; x++)
      for (int p = 0; p < 10; p++) begin
        if ($urandom % 100 < fb_bias) set_dn(x, p, 16 + $urandom % 6);
        else set_dn(x, p, $urandom % 32);
        set_def(x, p, (def_rate != 0) && ($urandom % def_rate == 0));
      end
    for (int j = 0; j < 12; j++) set_lut(j, 16'($urandom));
  endtask

  // R2: serial load, LSB of the image first, with idle gaps
  task automatic load();
    for (int i = 0; i < W; i++) begin
      if ($urandom % 4 == 0) begin
        cfg_valid = 1'b0; cfg_bit = 1'($urandom); @(negedge clk);
      end
      cfg_valid = 1'b1; cfg_bit = img[i]; @(negedge clk);
    end
    cfg_valid = 1'b0;
  endtask

  task automatic drive(input bit rf);
    ext_in  = 24'($urandom);
    cfg_bit = 1'($urandom);
    if (rf) begin
      flt_en  = ($urandom % 3 == 0);
      flt_idx = 6'($urandom);
      flt_val = 1'($urandom);
    end
    mq = model(img, ext_in, mq, flt_en, flt_idx, flt_val);
  endtask

  // mode 0: model only; 1: toggle/copy (R6); 2: stuck copy (R8); 3: rerouted (R9, R7)
  task automatic run(input int n, input string tag, input bit rf, input int mode);
    logic p8;
    mq = clu_out;
    p8 = clu_out[8];
    drive(rf);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, 32'(clu_out), 32'(mq));
      if (mode == 1) begin
        chk("R6 copy of feedback one cycle later", 32'(clu_out[0]), 32'(p8));
        chk("R6 feedback toggle", 32'(clu_out[8]), 32'(!p8));
      end else if (mode == 2) begin
        chk("R8 stuck route", 32'(clu_out[0]), 32'd1);
      end else if (mode == 3) begin
        chk("R9 rerouted copy", 32'(clu_out[0]), 32'(p8));
        chk("R7 defect pin reads 0", 32'(clu_out[1]), 32'd0);
      end
      p8 = clu_out[8];
      drive(rf);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    img = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 out in reset", 32'(clu_out), 32'd0);
      chk("R1 ready in reset", 32'(cfg_ready), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(cfg_ready), 32'd1);
    run(20, "R1 zero image", 1'b0, 0);
    chk("R1 outputs zero", 32'(clu_out), 32'd0);

    rand_img(10, 0); load();
    run(400, "R2 R3 R4 R5 R10 random image", 1'b0, 0);
    rand_img(50, 0); load();
    run(300, "R4 R6 feedback-heavy image", 1'b0, 0);
    rand_img(40, 6); load();
    run(400, "R7 R8 defects and faults", 1'b1, 0);

    // directed: block 8 toggles, block 0 copies it via broadcast code 18 in crossbar 0
    flt_en = 1'b0;
    img = '0;
    for (int b = 0; b < 16; b++) set_up(b, 31);
    for (int x = 0; x < 4; x++)
      for (int p = 0; p < 10; p++) set_dn(x, p, 31);
    set_dn(0, 8, 18); set_lut(8, 16'h5555);
    set_dn(0, 0, 18); set_lut(0, 16'hAAAA);
    load();
    run(30, "R4 R6 directed toggle", 1'b0, 1);
    flt_en = 1'b1; flt_idx = 6'd16; flt_val = 1'b1;
    run(20, "R8 directed fault", 1'b0, 2);

    // reroute through crossbar 1, mark crossbar 0 pin 0 defective
    set_def(0, 0, 1'b1);
    set_dn(1, 0, 18); set_lut(0, 16'hCCCC);
    set_dn(0, 1, 18); set_def(0, 1, 1'b1); set_lut(1, 16'hAAAA);
    load();
    run(30, "R9 R10 reroute with fault", 1'b0, 3);
    flt_idx = 6'd17; flt_val = 1'b1;
    run(20, "R7 defect overrides fault", 1'b0, 3);
    flt_idx = 6'd60;
    run(20, "R8 number above last selector", 1'b0, 3);

    summary();
    $finish;
  end
endmodule